// File: doc/BRIEF.md
# Thread Block to Warp Allocator

This block sits between a work distributor and one multiprocessor. It takes thread-block launch requests, each with a block identifier and a thread count, and places them onto the multiprocessor's warp slots. From the thread count it works out how many 32-lane warps the block needs. It admits the block only when a resident-block slot and enough warp slots are free. Once a block is admitted, the block emits one warp record per cycle. Each record carries the warp slot index, the owning block slot, the block identifier and an active-lane mask. The last warp of a block whose thread count is not a multiple of 32 gets a partial mask.

Requests with an illegal thread count are consumed at once with an error flag and leave no trace. A block-complete notice frees a block slot, together with every warp slot tagged with that block slot, in a single cycle. A free and an admission in the same cycle both take effect, and the admission check already sees the freed resources. Only one request is presented at a time. While a request cannot be admitted, the ready output stays low and the request waits in place.

Top module: `tb_warp_allocator`

## Requirements
- R1: An admitted request with T threads yields exactly ceil(T/32) warp records on consecutive cycles. The first record appears in the cycle after acceptance, and the last record is flagged with `warp_last_o`.
- R2: Every record except the last has an all-ones 32-bit lane mask. The last record's mask has bits [T mod 32 - 1 : 0] set, or all 32 bits set when T mod 32 is 0. Lane k maps to mask bit k.
- R3: Each record takes the lowest-numbered free warp slot (0 to 31), and that slot is then held by the block.
- R4: An admitted request takes the lowest-numbered free block slot (0 to 7). Each of its records carries that block slot and the request's block identifier.
- R5: When all 8 block slots are occupied, `req_ready_o` is low for a legal request until a block completes.
- R6: When fewer warp slots are free than the request needs, `req_ready_o` stays low and no record is emitted. The 32-slot total is never exceeded.
- R7: A thread count of 0 or above 512 makes `req_ready_o` and `req_err_o` high in the same cycle. The request is consumed, no record follows, and no slot is taken.
- R8: A complete notice for block slot s frees slot s and all warp slots tagged with s in one cycle, and a later request can reuse them.
- R9: When a complete notice and a request arrive in the same cycle, the admission check counts the resources freed in that cycle.
- R10: While records are being emitted, `req_ready_o` is low. A stalled request is neither dropped nor consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Launch request present |
| req_bid_i | input | 8 | Block identifier of the request |
| req_threads_i | input | 10 | Thread count of the request |
| req_ready_o | output | 1 | Request consumed this cycle (granted or rejected) |
| req_err_o | output | 1 | Request rejected for an illegal thread count |
| cmpl_valid_i | input | 1 | Block-complete notice |
| cmpl_bslot_i | input | 3 | Block slot being completed |
| warp_valid_o | output | 1 | Warp record valid |
| warp_slot_o | output | 5 | Allocated warp slot index |
| warp_bslot_o | output | 3 | Owning block slot |
| warp_bid_o | output | 8 | Owning block identifier |
| warp_mask_o | output | 32 | Active-lane mask of the warp |
| warp_last_o | output | 1 | Last warp of the block |

## Verification
The hardest state to reach is a complete warp-slot table with a request stalled against it, followed by a complete notice in the very cycle the request is waiting. Only that case shows whether the free is applied before the admission check. The stimulus gets there by first admitting a 512-thread block and an 11-warp block, so that all 32 slots are taken. It then holds a one-thread request for several cycles and drives the complete notice alongside it. The block limit is reached separately, with eight two-warp blocks that leave half the warp slots free. A stall in that case can only come from the block count.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  localparam int unsigned LANES_DEF   = 32;
  localparam int unsigned BLOCKS_DEF  = 8;
  localparam int unsigned WARPS_DEF   = 32;
  localparam int unsigned MAX_THR_DEF = 512;
  localparam int unsigned BID_W_DEF   = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } alloc_state_e;
endpackage

// File: rtl/lsb_pick.sv
module lsb_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    onehot_o = '0;
    idx_o    = '0;
    any_o    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        onehot_o = '0;
        onehot_o[i] = 1'b1;
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ones_count.sv
module ones_count #(
  parameter int unsigned N  = 32,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/warp_table.sv
module warp_table #(
  parameter int unsigned NW = 32,
  parameter int unsigned NB = 8,
  localparam int unsigned WIW = $clog2(NW),
  localparam int unsigned BIW = $clog2(NB),
  localparam int unsigned FCW = $clog2(NW + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           free_i,
  input  logic [BIW-1:0] free_bslot_i,
  input  logic           alloc_i,
  input  logic [BIW-1:0] alloc_bslot_i,
  output logic [WIW-1:0] pick_idx_o,
  output logic [FCW-1:0] free_cnt_o
);
  logic [NW-1:0]  used_q;
  logic [BIW-1:0] owner_q [NW];
  logic [NW-1:0]  match;
  logic [NW-1:0]  eff_free;
  logic [NW-1:0]  pick_oh;
  logic           pick_any;

  always_comb begin
    for (int i = 0; i < NW; i++)
      match[i] = free_i && used_q[i] && (owner_q[i] == free_bslot_i);
  end

  // free applies before the pick and the count
  assign eff_free = ~used_q | match;

  lsb_pick #(.N(NW)) u_pick (
    .req_i   (eff_free),
    .onehot_o(pick_oh),
    .idx_o   (pick_idx_o),
    .any_o   (pick_any)
  );

  ones_count #(.N(NW)) u_cnt (
    .vec_i(eff_free),
    .cnt_o(free_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
      for (int i = 0; i < NW; i++) owner_q[i] <= '0;
    end else begin
      used_q <= (used_q & ~match) | (alloc_i ? pick_oh : '0);
      for (int i = 0; i < NW; i++)
        if (alloc_i && pick_oh[i]) owner_q[i] <= alloc_bslot_i;
    end
  end

  // R3: reservation at admission guarantees a free slot for every record
  a_r3_slot_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> pick_any);

  // R8: after a free, no surviving slot is tagged with the freed block
  a_r8_tags_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |=> ((used_q & ~$past(alloc_i ? pick_oh : '0) & $past(match)) == '0));

  // R6: never more allocations than slots
  a_r6_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(used_q) == NW |-> !alloc_i || free_i);
endmodule

// File: rtl/tb_warp_allocator.sv
module tb_warp_allocator
  import alloc_pkg::*;
#(
  parameter int unsigned LANES   = LANES_DEF,
  parameter int unsigned NB      = BLOCKS_DEF,
  parameter int unsigned NW      = WARPS_DEF,
  parameter int unsigned MAX_THR = MAX_THR_DEF,
  parameter int unsigned BID_W   = BID_W_DEF,
  localparam int unsigned CNT_W = $clog2(MAX_THR) + 1,
  localparam int unsigned LSH   = $clog2(LANES),
  localparam int unsigned WIW   = $clog2(NW),
  localparam int unsigned BIW   = $clog2(NB),
  localparam int unsigned FCW   = $clog2(NW + 1),
  localparam int unsigned LW    = $clog2(MAX_THR / LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [BID_W-1:0] req_bid_i,
  input  logic [CNT_W-1:0] req_threads_i,
  output logic             req_ready_o,
  output logic             req_err_o,
  input  logic             cmpl_valid_i,
  input  logic [BIW-1:0]   cmpl_bslot_i,
  output logic             warp_valid_o,
  output logic [WIW-1:0]   warp_slot_o,
  output logic [BIW-1:0]   warp_bslot_o,
  output logic [BID_W-1:0] warp_bid_o,
  output logic [LANES-1:0] warp_mask_o,
  output logic             warp_last_o
);
  alloc_state_e     state_q;
  logic [NB-1:0]    blk_used_q;
  logic [BIW-1:0]   cur_bslot_q;
  logic [BID_W-1:0] cur_bid_q;
  logic [LW-1:0]    left_q;
  logic [LANES-1:0] tail_mask_q;

  logic [NB-1:0]    blk_clr, blk_eff_free, blk_oh;
  logic [BIW-1:0]   blk_idx;
  logic             blk_any;
  logic [FCW-1:0]   warp_free_cnt;
  logic [CNT_W:0]   thr_sum;
  logic [CNT_W:0]   need;
  logic [LSH-1:0]   rem;
  logic [LANES-1:0] tail_mask;
  logic             bad, fit, idle, accept, emit;

  assign blk_clr      = cmpl_valid_i ? (NB'(1) << cmpl_bslot_i) : '0;
  assign blk_eff_free = ~blk_used_q | blk_clr;

  lsb_pick #(.N(NB)) u_blk_pick (
    .req_i   (blk_eff_free),
    .onehot_o(blk_oh),
    .idx_o   (blk_idx),
    .any_o   (blk_any)
  );

  assign thr_sum   = {1'b0, req_threads_i} + (CNT_W+1)'(LANES - 1);
  assign need      = thr_sum >> LSH;
  assign rem       = req_threads_i[LSH-1:0];
  assign tail_mask = (rem == '0) ? '1 : ((LANES'(1) << rem) - LANES'(1));

  assign bad    = (req_threads_i == '0) || (req_threads_i > CNT_W'(MAX_THR));
  assign fit    = blk_any && ((CNT_W+1)'(warp_free_cnt) >= need);
  assign idle   = (state_q == ST_IDLE);
  assign emit   = (state_q == ST_EMIT);

  assign req_ready_o = idle && (bad || fit);
  assign req_err_o   = idle && req_valid_i && bad;
  assign accept      = req_valid_i && req_ready_o && !bad;

  warp_table #(.NW(NW), .NB(NB)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .free_i       (cmpl_valid_i),
    .free_bslot_i (cmpl_bslot_i),
    .alloc_i      (emit),
    .alloc_bslot_i(cur_bslot_q),
    .pick_idx_o   (warp_slot_o),
    .free_cnt_o   (warp_free_cnt)
  );

  assign warp_valid_o = emit;
  assign warp_last_o  = emit && (left_q == LW'(1));
  assign warp_bslot_o = cur_bslot_q;
  assign warp_bid_o   = cur_bid_q;
  assign warp_mask_o  = warp_last_o ? tail_mask_q : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      blk_used_q  <= '0;
      cur_bslot_q <= '0;
      cur_bid_q   <= '0;
      left_q      <= '0;
      tail_mask_q <= '0;
    end else begin
      blk_used_q <= (blk_used_q & ~blk_clr) | (accept ? blk_oh : '0);
      if (accept) begin
        state_q     <= ST_EMIT;
        cur_bslot_q <= blk_idx;
        cur_bid_q   <= req_bid_i;
        left_q      <= LW'(need);
        tail_mask_q <= tail_mask;
      end else if (emit) begin
        left_q <= left_q - LW'(1);
        if (left_q == LW'(1)) state_q <= ST_IDLE;
      end
    end
  end

  a_r7_err_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_err_o) |=> !warp_valid_o);

  a_r10_busy_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warp_valid_o |-> !req_ready_o);

  a_r2_full_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warp_valid_o && !warp_last_o) |-> (warp_mask_o == '1));

  a_r1_burst_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warp_valid_o && warp_last_o) |=> !warp_valid_o);

  a_r1_burst_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> warp_valid_o);

  a_r4_bid_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warp_valid_o && !warp_last_o) |=> ($stable(warp_bid_o) && $stable(warp_bslot_o)));
endmodule

// File: tb/sim_tb_warp_allocator.sv
module sim_tb_warp_allocator;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_bid = '0;
  logic [9:0]  req_thr = '0;
  logic        req_ready, req_err;
  logic        cmpl_valid = 1'b0;
  logic [2:0]  cmpl_bslot = '0;
  logic        w_valid, w_last;
  logic [4:0]  w_slot;
  logic [2:0]  w_bslot;
  logic [7:0]  w_bid;
  logic [31:0] w_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit m_wused [32];
  int m_wown  [32];
  bit m_bused [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  tb_warp_allocator u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_bid_i(req_bid), .req_threads_i(req_thr),
    .req_ready_o(req_ready), .req_err_o(req_err),
    .cmpl_valid_i(cmpl_valid), .cmpl_bslot_i(cmpl_bslot),
    .warp_valid_o(w_valid), .warp_slot_o(w_slot), .warp_bslot_o(w_bslot),
    .warp_bid_o(w_bid), .warp_mask_o(w_mask), .warp_last_o(w_last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mask(input int thr);
    int r = thr % 32;
    return (r == 0) ? 32'hFFFF_FFFF : ((32'h1 << r) - 32'h1);
  endfunction

  function automatic int low_warp();
    for (int i = 0; i < 32; i++) if (!m_wused[i]) return i;
    return -1;
  endfunction

  function automatic int low_blk();
    for (int i = 0; i < 8; i++) if (!m_bused[i]) return i;
    return -1;
  endfunction

  function automatic void model_free(input int b);
    m_bused[b] = 1'b0;
    for (int i = 0; i < 32; i++) if (m_wused[i] && m_wown[i] == b) m_wused[i] = 1'b0;
  endfunction

  // records are checked starting at the negedge after the accepting posedge
  task automatic collect(input int bid, input int thr, input int bs);
    int n = (thr + 31) / 32;
    for (int k = 0; k < n; k++) begin
      int s = low_warp();
      logic [31:0] em = (k == n - 1) ? exp_mask(thr) : 32'hFFFF_FFFF;
      if (k > 0) @(negedge clk);
      chk(w_valid == 1'b1, "R1 record valid", 32'(w_valid), 1);
      chk(w_slot == 5'(s), "R3 lowest warp slot", 32'(w_slot), 32'(s));
      chk(w_bslot == 3'(bs), "R4 block slot", 32'(w_bslot), 32'(bs));
      chk(w_bid == 8'(bid), "R4 block id", 32'(w_bid), 32'(bid));
      chk(w_mask == em, "R2 lane mask", w_mask, em);
      chk(w_last == (k == n - 1), "R1 last flag", 32'(w_last), 32'(k == n - 1));
      m_wused[s] = 1'b1;
      m_wown[s]  = bs;
    end
    @(negedge clk);
    chk(w_valid == 1'b0, "R1 burst length", 32'(w_valid), 0);
  endtask

  task automatic t_grant(input int bid, input int thr);
    int bs = low_blk();
    @(negedge clk);
    req_valid = 1'b1; req_bid = 8'(bid); req_thr = 10'(thr);
    #1;
    chk(req_ready == 1'b1, "R6 admit when room", 32'(req_ready), 1);
    chk(req_err == 1'b0, "R7 no error on legal", 32'(req_err), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 ready low while emitting", 32'(req_ready), 0);
    m_bused[bs] = 1'b1;
    collect(bid, thr, bs);
  endtask

  task automatic t_reject(input int thr);
    @(negedge clk);
    req_valid = 1'b1; req_bid = 8'hEE; req_thr = 10'(thr);
    #1;
    chk(req_ready == 1'b1, "R7 illegal consumed", 32'(req_ready), 1);
    chk(req_err == 1'b1, "R7 error flag", 32'(req_err), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(w_valid == 1'b0, "R7 no record after reject", 32'(w_valid), 0);
  endtask

  task automatic t_complete(input int b);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_bslot = 3'(b);
    @(negedge clk);
    cmpl_valid = 1'b0;
    model_free(b);
  endtask

  task automatic t_stall(input int thr, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_bid = 8'h55; req_thr = 10'(thr);
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(req_ready == 1'b0, req, 32'(req_ready), 0);
      chk(w_valid == 1'b0, "R10 stalled request emits nothing", 32'(w_valid), 0);
      @(negedge clk);
    end
  endtask

  // request stays asserted from t_stall; a complete is driven in the same cycle
  task automatic t_free_and_admit(input int b, input int thr, input string req);
    int bs;
    cmpl_valid = 1'b1; cmpl_bslot = 3'(b);
    #1;
    chk(req_ready == 1'b1, req, 32'(req_ready), 1);
    @(negedge clk);
    cmpl_valid = 1'b0; req_valid = 1'b0;
    model_free(b);
    bs = low_blk();
    m_bused[bs] = 1'b1;
    collect(8'h55, thr, bs);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin m_wused[i] = 1'b0; m_wown[i] = 0; end
    for (int i = 0; i < 8; i++) m_bused[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(w_valid == 1'b0, "R1 no record after reset", 32'(w_valid), 0);
    req_thr = 10'd32; #1;
    chk(req_ready == 1'b1, "R6 ready after reset", 32'(req_ready), 1);

    t_grant(8'h11, 70);          // 3 warps, partial tail
    t_grant(8'h22, 32);          // exact warp
    t_reject(0);
    t_reject(513);
    t_grant(8'h33, 1);           // shows rejects took no slot
    t_complete(0);
    t_grant(8'h44, 96);          // R8 reuse of freed slots
    t_grant(8'h66, 512);
    t_grant(8'h77, 352);         // table now full
    t_stall(1, "R6 stall on warp limit");
    t_free_and_admit(1, 1, "R9 free counted same cycle");
    for (int b = 0; b < 5; b++) t_complete(b);
    for (int b = 0; b < 8; b++) t_grant(8'h80 + b, 40);
    t_stall(1, "R5 stall on block limit");
    t_free_and_admit(5, 1, "R5 admit after block freed");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule